// File: doc/BRIEF.md
# HDLC Transmit Buffer Sequencer

This block serves one transmit buffer at a time. A buffer is handed over as a descriptor: a 16-bit control word, a 16-bit byte count and a 32-bit start address. The block fetches the buffer's bytes one by one through a synchronous byte-read memory port. Read data may return after a variable number of cycles. Each byte is passed to a downstream HDLC framer over a valid/ready stream. The stream carries qualifiers for end of frame, append CRC, a data-free end-of-frame marker, and an abort pulse. Flag generation, bit stuffing, CRC arithmetic and the serial line all belong to the framer.

The control bits of each descriptor steer how the buffer ends. One bit marks the buffer as closing the frame. A second bit, on such a buffer, asks for a CRC rather than a bare closing flag. A third bit asks for an event when the buffer completes cleanly. The block watches the clear-to-send line while the buffer is active. It also gives up on a memory read that stays silent too long while the framer is ready. When the buffer closes, the block presents a one-cycle write-back word. In that word the ready bit is cleared, the reserved bits are zero, and the underrun and CTS-lost status bits are filled in. In the same cycle the block raises a buffer-done or buffer-error event pulse. A new descriptor is taken only after that cycle.

Stream rules: a beat transfers on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the beat and all its qualifiers stay unchanged. `tx_abort` is a single-cycle pulse and is not handshaked. The descriptor input transfers when `bd_valid` and `bd_ready` are both high.

Top module: `hdlc_txbd_seq`

## Requirements
- R1: After reset, `bd_ready` is 1 and `tx_valid`, `tx_abort`, `mem_rd_en`, `wb_valid`, `ev_buf_done` and `ev_buf_err` are 0.
- R2: For a byte count N > 0 with no underrun, exactly N data beats are sent. Beat i carries the byte read from start address + i, in increasing address order.
- R3: While `tx_valid` is 1 and `tx_ready` is 0, the next cycle still shows `tx_valid` = 1 with unchanged `tx_data`, `tx_last`, `tx_crc` and `tx_empty`.
- R4: Control bit 11 (last in frame) = 1 sets `tx_last` on the final data beat only. With bit 11 = 0, no beat of the buffer carries `tx_last`.
- R5: `tx_crc` equals control bit 10 on a beat that carries `tx_last`, and is 0 on every other beat.
- R6: A byte count of 0 closes the buffer without any memory read. With bit 11 = 1, exactly one beat is sent first, with `tx_empty` = 1, `tx_last` = 1 and `tx_crc` = bit 10. With bit 11 = 0, no beat is sent.
- R7: A memory read may stay unanswered for at most `UR_LIMIT` cycles in which `tx_ready` is 1; the data is accepted if it arrives within that window. If it has not arrived by then, `tx_abort` pulses for one cycle, no further beats of the buffer are sent, and the buffer closes with the underrun bit (bit 1) = 1.
- R8: If `line_cts` is 0 in any cycle from the cycle after acceptance up to the close, write-back bit 0 (CTS lost) = 1. `line_cts` low while no buffer is active has no effect.
- R9: On close, `wb_valid` is high for exactly one cycle. In that cycle, `wb_ctrl` has bit 15 = 0, bits 14..10 copied from the descriptor, bits 9..2 = 0, bit 1 = underrun and bit 0 = CTS lost. The descriptor's own values in bits 9..0 are ignored.
- R10: The event pulses appear only in the `wb_valid` cycle. `ev_buf_done` = 1 when control bit 12 is 1 and neither status bit is set. `ev_buf_err` = 1 whenever underrun or CTS lost is set, whatever bit 12 holds. The two pulses are never high together.
- R11: `bd_ready` is 0 from the cycle after acceptance through the `wb_valid` cycle, and is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bd_valid | input | 1 | Descriptor offered |
| bd_ready | output | 1 | Block idle, descriptor taken when `bd_valid` is high |
| bd_ctrl | input | 16 | Descriptor control word |
| bd_len | input | 16 | Byte count |
| bd_addr | input | 32 | Address of the first byte |
| mem_rd_en | output | 1 | One-cycle byte read request |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_valid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | 8 | Returned byte |
| tx_valid | output | 1 | Beat offered to framer |
| tx_ready | input | 1 | Framer accepts beat |
| tx_data | output | 8 | Data byte |
| tx_last | output | 1 | Beat ends the frame |
| tx_crc | output | 1 | Append CRC after this end-of-frame beat |
| tx_empty | output | 1 | Beat carries no data (end-of-frame marker only) |
| tx_abort | output | 1 | One-cycle abort pulse on underrun |
| line_cts | input | 1 | Clear-to-send, high when granted |
| wb_valid | output | 1 | Write-back word valid, buffer closed |
| wb_ctrl | output | 16 | Write-back control/status word |
| ev_buf_done | output | 1 | Buffer closed cleanly with event requested |
| ev_buf_err | output | 1 | Buffer closed with an error |

## Verification
Random buffers mix lengths from zero to a dozen bytes and random control bits, including set reserved and status bits. They are sent with random framer back-pressure and memory latencies of one to three cycles. Together these separate address ordering, qualifier placement and stall holding from one another. Directed buffers set the read latency to exactly the underrun limit and to one past it, to pin down the boundary of the underrun rule. They also drop the read of a byte mid-buffer, to separate a partial frame with abort from a complete one. A clear-to-send drop during a buffer is compared with one during idle, so that status capture is told apart from a level that is merely sampled. The two zero-length cases show the data-free end-of-frame marker against a silent close.

// File: rtl/hdlc_txbd_pkg.sv
package hdlc_txbd_pkg;
  localparam int CTRL_W  = 16;
  localparam int BIT_RDY = 15;
  localparam int BIT_IRQ = 12;
  localparam int BIT_LST = 11;
  localparam int BIT_CRC = 10;
  localparam int BIT_UN  = 1;
  localparam int BIT_CT  = 0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_SEND,
    S_EMPTY,
    S_ABORT,
    S_CLOSE
  } seq_state_t;
endpackage

// File: rtl/hdlc_txbd_cursor.sv
module hdlc_txbd_cursor #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last_one
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      rem_q <= '0;
    end else if (load) begin
      addr  <= load_addr;
      rem_q <= load_len;
    end else if (step) begin
      addr  <= addr + 1'b1;
      rem_q <= rem_q - 1'b1;
    end
  end

  assign last_one = (rem_q == LEN_W'(1));
endmodule

// File: rtl/hdlc_txbd_ur_timer.sv
module hdlc_txbd_ur_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic fire
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (tick)       cnt_q <= cnt_q + 1'b1;
  end

  // fires on the LIMIT-th ready cycle spent without read data
  assign fire = tick && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/hdlc_txbd_wb_pack.sv
module hdlc_txbd_wb_pack
  import hdlc_txbd_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              un,
  input  logic              ct,
  output logic [CTRL_W-1:0] word,
  output logic              ev_ok,
  output logic              ev_err
);
  // copied user bits sit between the CRC select and the ready bit
  localparam logic [CTRL_W-1:0] KEEP =
    ((CTRL_W'(1) << BIT_RDY) - 1'b1) & ~((CTRL_W'(1) << BIT_CRC) - 1'b1);

  logic err;
  assign err = un | ct;

  always_comb begin
    word         = ctrl & KEEP;
    word[BIT_UN] = un;
    word[BIT_CT] = ct;
  end

  assign ev_ok  = ctrl[BIT_IRQ] & ~err;
  assign ev_err = err;
endmodule

// File: rtl/hdlc_txbd_seq.sv
module hdlc_txbd_seq
  import hdlc_txbd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int DATA_W   = 8,
  parameter int UR_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bd_valid,
  output logic              bd_ready,
  input  logic [CTRL_W-1:0] bd_ctrl,
  input  logic [LEN_W-1:0]  bd_len,
  input  logic [ADDR_W-1:0] bd_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_crc,
  output logic              tx_empty,
  output logic              tx_abort,
  input  logic              line_cts,
  output logic              wb_valid,
  output logic [CTRL_W-1:0] wb_ctrl,
  output logic              ev_buf_done,
  output logic              ev_buf_err
);
  seq_state_t        state_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] byte_q;
  logic              un_q;
  logic              ct_q;

  logic accept, step, last_one, ur_tick, ur_fire, active;
  logic ev_ok, ev_err;
  logic [CTRL_W-1:0] wb_word;

  assign accept  = (state_q == S_IDLE) && bd_valid;
  assign step    = (state_q == S_SEND) && tx_ready;
  assign ur_tick = (state_q == S_WAIT) && tx_ready && !mem_rd_valid;
  assign active  = (state_q != S_IDLE) && (state_q != S_CLOSE);

  hdlc_txbd_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (bd_addr),
    .load_len  (bd_len),
    .step      (step),
    .addr      (mem_rd_addr),
    .last_one  (last_one)
  );

  hdlc_txbd_ur_timer #(.LIMIT(UR_LIMIT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state_q != S_WAIT),
    .tick  (ur_tick),
    .fire  (ur_fire)
  );

  hdlc_txbd_wb_pack u_pack (
    .ctrl   (ctrl_q),
    .un     (un_q),
    .ct     (ct_q),
    .word   (wb_word),
    .ev_ok  (ev_ok),
    .ev_err (ev_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      byte_q  <= '0;
      un_q    <= 1'b0;
      ct_q    <= 1'b0;
    end else begin
      if (active && !line_cts) ct_q <= 1'b1;
      unique case (state_q)
        S_IDLE: if (bd_valid) begin
          ctrl_q <= bd_ctrl;
          un_q   <= 1'b0;
          ct_q   <= 1'b0;
          if (bd_len != '0)          state_q <= S_FETCH;
          else if (bd_ctrl[BIT_LST]) state_q <= S_EMPTY;
          else                       state_q <= S_CLOSE;
        end
        S_FETCH: state_q <= S_WAIT;
        S_WAIT: begin
          if (mem_rd_valid) begin
            byte_q  <= mem_rd_data;
            state_q <= S_SEND;
          end else if (ur_fire) begin
            un_q    <= 1'b1;
            state_q <= S_ABORT;
          end
        end
        S_SEND:  if (tx_ready) state_q <= last_one ? S_CLOSE : S_FETCH;
        S_EMPTY: if (tx_ready) state_q <= S_CLOSE;
        S_ABORT: state_q <= S_CLOSE;
        S_CLOSE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign bd_ready    = (state_q == S_IDLE);
  assign mem_rd_en   = (state_q == S_FETCH);
  assign tx_valid    = (state_q == S_SEND) || (state_q == S_EMPTY);
  assign tx_empty    = (state_q == S_EMPTY);
  assign tx_data     = (state_q == S_SEND) ? byte_q : '0;
  assign tx_last     = ctrl_q[BIT_LST] &&
                       (((state_q == S_SEND) && last_one) || (state_q == S_EMPTY));
  assign tx_crc      = tx_last && ctrl_q[BIT_CRC];
  assign tx_abort    = (state_q == S_ABORT);
  assign wb_valid    = (state_q == S_CLOSE);
  assign wb_ctrl     = wb_word;
  assign ev_buf_done = wb_valid && ev_ok;
  assign ev_buf_err  = wb_valid && ev_err;
endmodule

// File: rtl/hdlc_txbd_seq_chk.sv
module hdlc_txbd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bd_ready,
  input logic        mem_rd_en,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_crc,
  input logic        tx_empty,
  input logic        tx_abort,
  input logic        wb_valid,
  input logic [15:0] wb_ctrl,
  input logic        ev_buf_done,
  input logic        ev_buf_err
);
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)
                              && $stable(tx_crc) && $stable(tx_empty));

  p_crc_needs_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_crc |-> tx_last);

  p_empty_is_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_empty |-> tx_last);

  p_abort_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> wb_valid && wb_ctrl[1]);

  p_wb_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !wb_ctrl[15] && (wb_ctrl[9:2] == 8'h00));

  p_wb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  p_evt_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_buf_done && ev_buf_err));

  p_evt_at_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_buf_done || ev_buf_err) |-> wb_valid);

  p_err_matches_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (ev_buf_err == (wb_ctrl[1] || wb_ctrl[0])));

  p_busy_at_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !bd_ready);

  p_ready_after_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> bd_ready);

  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bd_ready |-> !tx_valid && !mem_rd_en && !tx_abort);
endmodule

bind hdlc_txbd_seq hdlc_txbd_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bd_ready    (bd_ready),
  .mem_rd_en   (mem_rd_en),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .tx_last     (tx_last),
  .tx_crc      (tx_crc),
  .tx_empty    (tx_empty),
  .tx_abort    (tx_abort),
  .wb_valid    (wb_valid),
  .wb_ctrl     (wb_ctrl),
  .ev_buf_done (ev_buf_done),
  .ev_buf_err  (ev_buf_err)
);

// File: tb/hdlc_txbd_seq_bench.sv
`timescale 1ns/100ps
module hdlc_txbd_seq_bench;
  localparam int UR_LIMIT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bd_valid = 1'b0;
  logic        bd_ready;
  logic [15:0] bd_ctrl = '0;
  logic [15:0] bd_len = '0;
  logic [31:0] bd_addr = '0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [7:0]  mem_rd_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_last, tx_crc, tx_empty, tx_abort;
  logic        line_cts = 1'b1;
  logic        wb_valid;
  logic [15:0] wb_ctrl;
  logic        ev_buf_done, ev_buf_err;

  int n_chk = 0;
  int n_bad = 0;
  bit all_done = 0;

  always #2 clk = ~clk;

  hdlc_txbd_seq #(.UR_LIMIT(UR_LIMIT)) u_hdlc_txbd_seq (
    .clk(clk), .rst_n(rst_n), .bd_valid(bd_valid), .bd_ready(bd_ready),
    .bd_ctrl(bd_ctrl), .bd_len(bd_len), .bd_addr(bd_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_crc(tx_crc), .tx_empty(tx_empty),
    .tx_abort(tx_abort), .line_cts(line_cts), .wb_valid(wb_valid),
    .wb_ctrl(wb_ctrl), .ev_buf_done(ev_buf_done), .ev_buf_err(ev_buf_err)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] c, input bit un, input bit ct);
    return {1'b0, c[14:10], 8'h00, un, ct};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_bd(input logic [15:0] ctrl, input int len, input logic [31:0] addr,
                        input int rdy_pct, input int lat_fix, input int drop_idx,
                        input int cts_cyc);
    bit lst = ctrl[11];
    bit crcb = ctrl[10];
    bit exp_un = (len > 0) && ((drop_idx >= 0) || (lat_fix > UR_LIMIT));
    bit exp_ct = (cts_cyc >= 0);
    int exp_beats = exp_un ? ((drop_idx >= 0) ? drop_idx : 0) : len;
    int nb = 0;
    int cyc = 0;
    int pend_cnt = 0;
    int idx;
    bit pend = 0;
    bit done = 0;
    bit empty_seen = 0;
    bit abort_seen = 0;
    bit busy_bad = 0;
    bit stall = 0;
    logic [7:0] pend_data = '0;
    logic [7:0] st_data = '0;
    logic st_last = 0;
    logic [15:0] ew;
    while (!bd_ready) @(negedge clk);
    bd_valid = 1'b1; bd_ctrl = ctrl; bd_len = 16'(len); bd_addr = addr;
    @(negedge clk);
    bd_valid = 1'b0;
    while (!done && cyc < 20000) begin
      mem_rd_valid = 1'b0;
      if (pend) begin
        if (pend_cnt <= 1) begin
          mem_rd_valid = 1'b1; mem_rd_data = pend_data; pend = 0;
        end else pend_cnt--;
      end
      tx_ready = (int'($urandom_range(99, 0)) < rdy_pct);
      line_cts = (cyc != cts_cyc);
      if (stall)
        chk(tx_valid && tx_data == st_data && tx_last == st_last, "R3",
            "stalled beat changed", {23'd0, tx_valid, tx_data}, {24'd1, st_data});
      if (mem_rd_en) begin
        idx = int'(mem_rd_addr - addr);
        if (len == 0) chk(0, "R6", "read on zero length", mem_rd_addr, addr);
        if (idx != drop_idx) begin
          pend = 1;
          pend_cnt = (lat_fix > 0) ? lat_fix : int'($urandom_range(3, 1));
          pend_data = mem_byte(mem_rd_addr);
        end
      end
      if (tx_valid && tx_ready) begin
        if (tx_empty) begin
          empty_seen = 1;
          chk(tx_last == 1'b1, "R6", "marker tx_last", 32'(tx_last), 1);
          chk(tx_crc == crcb, "R6", "marker tx_crc", 32'(tx_crc), 32'(crcb));
        end else begin
          chk(tx_data == mem_byte(addr + 32'(nb)), "R2", "beat data",
              32'(tx_data), 32'(mem_byte(addr + 32'(nb))));
          chk(tx_last == (lst && nb == len - 1), "R4", "tx_last", 32'(tx_last),
              32'(lst && nb == len - 1));
          chk(tx_crc == (crcb && lst && nb == len - 1), "R5", "tx_crc", 32'(tx_crc),
              32'(crcb && lst && nb == len - 1));
          nb++;
        end
      end
      stall = tx_valid && !tx_ready;
      st_data = tx_data; st_last = tx_last;
      if (tx_abort) abort_seen = 1;
      if (wb_valid) begin
        ew = exp_word(ctrl, exp_un, exp_ct);
        chk(wb_ctrl == ew, "R9", "write-back word", 32'(wb_ctrl), 32'(ew));
        chk(ev_buf_done == (ctrl[12] && !exp_un && !exp_ct), "R10", "done event",
            32'(ev_buf_done), 32'(ctrl[12] && !exp_un && !exp_ct));
        chk(ev_buf_err == (exp_un || exp_ct), "R10", "error event",
            32'(ev_buf_err), 32'(exp_un || exp_ct));
        chk(!bd_ready, "R11", "ready during close", 32'(bd_ready), 0);
        done = 1;
      end else if (bd_ready) busy_bad = 1;
      cyc++;
      @(negedge clk);
    end
    tx_ready = 1'b0; line_cts = 1'b1; mem_rd_valid = 1'b0;
    chk(done, "R9", "buffer closed", 32'(done), 1);
    chk(!wb_valid, "R9", "write-back one cycle", 32'(wb_valid), 0);
    chk(nb == exp_beats, "R2", "beat count", nb, exp_beats);
    chk(abort_seen == exp_un, "R7", "abort pulse", 32'(abort_seen), 32'(exp_un));
    chk(empty_seen == (len == 0 && lst), "R6", "marker beat", 32'(empty_seen),
        32'(len == 0 && lst));
    chk(!busy_bad && bd_ready, "R11", "ready after close", 32'(bd_ready && !busy_bad), 1);
  endtask

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    chk(bd_ready && !tx_valid && !tx_abort && !mem_rd_en && !wb_valid &&
        !ev_buf_done && !ev_buf_err, "R1", "reset outputs",
        {26'd0, bd_ready, tx_valid, tx_abort, mem_rd_en, wb_valid, ev_buf_err}, 32'h20);
    rst_n = 1'b1;
    @(negedge clk);
    // directed cases
    run_bd(16'h1C03 | 16'h03FC, 5, 32'h0000_1000, 100, 1, -1, -1);  // last+crc+irq, junk low bits
    run_bd(16'h1800, 4, 32'h0000_20F0, 50, 2, -1, -1);              // last, flag only
    run_bd(16'h1000, 3, 32'h0000_30FE, 70, 0, -1, -1);              // continues in next buffer
    run_bd(16'h1C00, 0, 32'h0000_4000, 60, 1, -1, -1);              // R6 empty with crc
    run_bd(16'h1000, 0, 32'h0000_4100, 60, 1, -1, -1);              // R6 silent close
    run_bd(16'h1800, 2, 32'h0000_5000, 100, UR_LIMIT, -1, -1);      // R7 latency at limit
    run_bd(16'h1800, 2, 32'h0000_5100, 100, UR_LIMIT + 1, -1, -1);  // R7 one past limit
    run_bd(16'h1C00, 6, 32'h0000_6000, 80, 0, 3, -1);               // R7 mid-buffer underrun
    run_bd(16'h0800, 3, 32'h0000_7000, 90, 0, -1, 2);               // R8 cts lost, irq clear
    line_cts = 1'b0;                                                // R8 idle drop ignored
    repeat (3) @(negedge clk);
    line_cts = 1'b1;
    run_bd(16'h1800, 3, 32'h0000_8000, 90, 0, -1, -1);
    // random buffers
    for (int k = 0; k < 40; k++) begin
      logic [15:0] c = 16'($urandom());
      int ln = int'($urandom_range(12, 0));
      int dr = -1;
      int cc = -1;
      if (ln > 0 && $urandom_range(7, 0) == 0) dr = int'($urandom_range(ln - 1, 0));
      if (ln > 0 && $urandom_range(5, 0) == 0) cc = int'($urandom_range(2, 1));
      run_bd(c, ln, $urandom(), int'($urandom_range(100, 30)), 0, dr, cc);
    end
    all_done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!all_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule